// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of small saturating counters with one row for each of `ROWS` instruction-address slots. Each row holds one counter for every possible value of a global history register. The history register records the outcomes of the most recent `HIST_W` resolved branches. To make a prediction, the block takes the word-aligned address modulo the row count to pick the row, and the current history to pick the counter in that row. The prediction is the top bit of that counter, and it is produced combinationally.

When a branch resolves, the update port takes the same address and the real outcome. The counter is selected with the history as it stands before the update, moves one step toward the outcome, and the history then shifts the outcome in. The history changes only on resolution and never on prediction.

After reset, the block steps through the table one row per cycle and loads every counter with its initial value. It holds `busy` high while it does this. During the sweep it predicts not-taken and ignores updates.

Top module: `gselect_predictor`

## Requirements
- R1: After reset is released, `busy` is high for exactly `ROWS` clock cycles (128 by default), then falls and stays low until the next reset.
- R2: While `busy` is high, `predTaken` is 0 and an asserted `updValid` has no effect: after the sweep, the history is 000 and every counter holds its initial value.
- R3: Once the sweep ends, every counter holds 01 and the history is 000, so every address is predicted not-taken.
- R4: The row index is address bits [8:2], which is (pc >> 2) modulo 128. Address bits [1:0] and [31:9] do not affect which counter is used.
- R5: The counter used for both predicting and updating is the one at column = current 3-bit history. `predTaken` is 1 exactly when that counter is 2 or 3.
- R6: A resolved taken outcome increments the selected counter, saturating at 3. A not-taken outcome decrements it, saturating at 0.
- R7: On each accepted update, the history becomes ((old << 1) | outcome) masked to 3 bits. The counter that changes is the one selected by the old history.
- R8: When a prediction and an update happen in the same cycle, `predTaken` reflects the table and history as they were before that update.
- R9: A cycle with `updValid` low changes neither the history nor any counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| predPc | input | 32 | Address of the branch being predicted |
| predTaken | output | 1 | Combinational direction guess, 1 = taken |
| updValid | input | 1 | A branch outcome is presented this cycle |
| updPc | input | 32 | Address of the resolved branch |
| updTaken | input | 1 | Resolved outcome, 1 = taken |
| busy | output | 1 | Initialization sweep in progress |

## Verification
The two hardest effects to see from the ports are a counter pinned at a saturation limit and the use of the old history when an update is applied. The history cannot be read directly, and it moves on every update, so the same counter is reached again only through certain outcome patterns. The stimulus confines updates to a few rows and biases the outcomes into long taken or not-taken runs. This drives the history to all-ones or all-zeros, so the same column is hit repeatedly and its counter is pushed to its limit. A reference table in the bench then checks every prediction, including predictions made through aliased addresses and in the same cycle as an update.

// File: rtl/gsel_pkg.sv
package gsel_pkg;
  typedef struct packed {
    logic initWr;  // load one row with initial counters
    logic updWr;   // apply a resolved outcome
    logic predEn;  // prediction output allowed
  } ctrlStrb_t;
endpackage

// File: rtl/gsel_ctrl.sv
module gsel_ctrl
  import gsel_pkg::*;
#(
  parameter int ROWS  = 128,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             updValid,
  output ctrlStrb_t        strb,
  output logic [ROW_W-1:0] sweepRow,
  output logic             busy
);
  logic busyQ;
  logic [ROW_W-1:0] rowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b1;
      rowCnt <= '0;
    end else if (busyQ) begin
      rowCnt <= rowCnt + 1'b1;
      if (rowCnt == ROW_W'(ROWS - 1)) busyQ <= 1'b0;
    end
  end

  always_comb begin
    strb.initWr = busyQ;
    strb.updWr  = updValid && !busyQ;
    strb.predEn = !busyQ;
  end

  assign sweepRow = rowCnt;
  assign busy     = busyQ;
endmodule

// File: rtl/gsel_datapath.sv
module gsel_datapath
  import gsel_pkg::*;
#(
  parameter int HIST_W   = 3,
  parameter int CTR_W    = 2,
  parameter int CTR_INIT = 1,
  parameter int ROWS     = 128,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COLS  = 1 << HIST_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [ROW_W-1:0]  sweepRow,
  input  logic [ROW_W-1:0]  predRow,
  input  logic [ROW_W-1:0]  updRow,
  input  logic              updTaken,
  output logic              predTaken,
  output logic [HIST_W-1:0] histQ
);
  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};

  logic [CTR_W-1:0] tbl [ROWS][COLS];
  logic [CTR_W-1:0] curCtr, nextCtr;
  logic [HIST_W:0]  histWide;

  always_comb begin
    curCtr  = tbl[updRow][histQ];
    nextCtr = curCtr;
    if (updTaken && curCtr != CTR_MAX)      nextCtr = curCtr + 1'b1;
    else if (!updTaken && curCtr != '0)     nextCtr = curCtr - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.initWr) begin
      for (int c = 0; c < COLS; c++) tbl[sweepRow][c] <= CTR_W'(CTR_INIT);
    end else if (strb.updWr) begin
      tbl[updRow][histQ] <= nextCtr;
    end
  end

  assign histWide = {histQ, updTaken};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            histQ <= '0;
    else if (strb.updWr)  histQ <= histWide[HIST_W-1:0];
  end

  assign predTaken = strb.predEn && tbl[predRow][histQ][CTR_W-1];
endmodule

// File: rtl/gselect_predictor.sv
module gselect_predictor
  import gsel_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int HIST_W   = 3,
  parameter int CTR_W    = 2,
  parameter int CTR_INIT = 1,
  parameter int ROWS     = 128,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] predPc,
  output logic            predTaken,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  output logic            busy
);
  ctrlStrb_t         strb;
  logic [ROW_W-1:0]  sweepRow;
  logic [ROW_W-1:0]  predRow, updRow;
  logic [HIST_W-1:0] histQ;
  logic              unusedPcBits;

  assign predRow = predPc[2 +: ROW_W];
  assign updRow  = updPc[2 +: ROW_W];
  assign unusedPcBits = ^{predPc[1:0], predPc[PC_W-1:ROW_W+2],
                          updPc[1:0], updPc[PC_W-1:ROW_W+2]};

  gsel_ctrl #(.ROWS(ROWS)) u_ctrl (
    .clk(clk), .rstN(rstN), .updValid(updValid),
    .strb(strb), .sweepRow(sweepRow), .busy(busy)
  );

  gsel_datapath #(.HIST_W(HIST_W), .CTR_W(CTR_W), .CTR_INIT(CTR_INIT), .ROWS(ROWS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sweepRow(sweepRow),
    .predRow(predRow), .updRow(updRow), .updTaken(updTaken),
    .predTaken(predTaken), .histQ(histQ)
  );
endmodule

// File: rtl/gsel_checker.sv
module gsel_checker #(
  parameter int HIST_W = 3,
  parameter int ROWS   = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              predTaken,
  input logic              updValid,
  input logic              updTaken,
  input logic [HIST_W-1:0] hist
);
  localparam int CW = $clog2(ROWS) + 2;
  logic [CW-1:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
  end

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyCnt == CW'(ROWS));  // R1
  AST_BUSY_NO_RERISE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> !busy);  // R1
  AST_NO_PRED_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !predTaken);  // R2
  AST_HIST_CLEAR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> hist == '0);  // R2
  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !busy) |=> hist == HIST_W'(({1'b0, $past(hist)} << 1) | $past(updTaken)));  // R7
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> $stable(hist));  // R9
endmodule

bind gselect_predictor gsel_checker #(.HIST_W(HIST_W), .ROWS(ROWS)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .predTaken(predTaken),
  .updValid(updValid), .updTaken(updTaken), .hist(histQ)
);

// File: tb/test_gselect_predictor.sv
`timescale 1ns/1ps
module test_gselect_predictor;
  localparam int ROWS = 128;
  localparam int COLS = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] predPc = '0;
  logic predTaken;
  logic updValid = 1'b0;
  logic [31:0] updPc = '0;
  logic updTaken = 1'b0;
  logic busy;

  int checks = 0;
  int errors = 0;
  int mdl [ROWS][COLS];
  int hist = 0;
  logic [31:0] lfsr = 32'hACE1_2357;

  always #2 clk = ~clk;

  gselect_predictor i_gselect_predictor (
    .clk(clk), .rstN(rstN), .predPc(predPc), .predTaken(predTaken),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rowOf(input logic [31:0] pc);
    return int'((pc >> 2) % ROWS);
  endfunction

  function automatic int mdlPred(input logic [31:0] pc);
    return (mdl[rowOf(pc)][hist] >= 2) ? 1 : 0;
  endfunction

  task automatic mdlUpdate(input logic [31:0] pc, input logic t);
    int r;
    r = rowOf(pc);
    if (t && mdl[r][hist] < 3) mdl[r][hist]++;
    else if (!t && mdl[r][hist] > 0) mdl[r][hist]--;
    hist = ((hist << 1) | int'(t)) & 7;
  endtask

  function automatic logic [31:0] aliasPc(input logic [31:0] pc, input logic [31:0] noise);
    return {noise[31:9], pc[8:2], noise[1:0]};
  endfunction

  task automatic stepLfsr();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  // one resolved branch; prediction checked in the same cycle (R8)
  task automatic resolve(input logic [31:0] pc, input logic t, input string req);
    @(negedge clk);
    updValid = 1'b1; updPc = pc; updTaken = t;
    predPc = aliasPc(pc, ~lfsr);
    #1 check(req, int'(predTaken), mdlPred(pc));
    @(posedge clk);
    mdlUpdate(pc, t);
    @(negedge clk);
    updValid = 1'b0;
  endtask

  task automatic predCheck(input logic [31:0] pc, input string req);
    predPc = pc;
    #1 check(req, int'(predTaken), mdlPred(pc));
  endtask

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) mdl[r][c] = 1;
    repeat (3) @(negedge clk);
    // hold a taken update on row 5 through the whole sweep (R2)
    updValid = 1'b1; updPc = 32'h0000_0014; updTaken = 1'b1; predPc = 32'h14;
    rstN = 1'b1;
    begin
      int cnt = 0;
      int sawPred = 0;
      check("R1 busy after reset", int'(busy), 1);
      while (busy) begin
        if (predTaken) sawPred = 1;
        @(negedge clk);
        if (!busy) updValid = 1'b0;
        cnt++;
      end
      check("R1 sweep length", cnt, ROWS);
      check("R2 no prediction while busy", sawPred, 0);
    end
    // R3 R2: every row predicted not-taken at history 0
    for (int r = 0; r < ROWS; r++) predCheck(32'(r * 4), "R3 init not-taken");
    predCheck(32'h14, "R2 busy update ignored");
    // R9: idle cycles change nothing
    repeat (5) @(negedge clk);
    predCheck(32'h14, "R9 idle no change");
    // R6 R7 directed: row 9 runs of taken then not-taken
    for (int i = 0; i < 6; i++) resolve(32'h24, 1'b1, "R6 taken run");
    predCheck(32'h24, "R6 saturated high");
    resolve(32'h24, 1'b0, "R7 old history used");
    predCheck(32'h24, "R7 new column");
    for (int i = 0; i < 8; i++) resolve(32'h24, 1'b0, "R6 not-taken run");
    resolve(32'h24, 1'b1, "R6 saturated low");
    predCheck(32'h24, "R6 after low saturation");
    // R4 R5: aliased addresses see the same counters
    for (int k = 0; k < 16; k++) predCheck(aliasPc(32'h24, 32'(k * 32'h1357_9BDF)), "R4 alias");
    // random biased training on a few rows
    for (int i = 0; i < 3000; i++) begin
      logic t;
      logic [31:0] pc;
      stepLfsr();
      pc = {lfsr[31:9], 5'd0, lfsr[1:0], lfsr[3:2]};
      t = ((i / 40) % 2 == 0) ? (lfsr[7:5] != 0) : (lfsr[7:5] == 0);
      resolve(pc, t, "R8 same-cycle predict");
      stepLfsr();
      predCheck(aliasPc({25'd0, lfsr[4:0], 2'd0}, lfsr), "R5 R6 R7 trained");
    end
    // full sweep of all rows at the final history
    for (int r = 0; r < ROWS; r++) predCheck(32'(r * 4), "R4 R5 final table");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule